// File: doc/BRIEF.md
# E1 Time-Slot-0 National-Bit Data Link Inserter

This block sits in the transmit path of an E1 line and writes a serial data link into the national-use (Sa) bits of time slot 0. The outgoing stream arrives one bit per cycle in which `bit_vld` is high. A frame pulse marks the first bit of a frame-alignment frame. An internal counter then follows the 256-bit frame and tells frame-alignment frames apart from the frames that carry the national bits.

Each of Sa4 to Sa8 has its own enable in a small configuration register. The data-link bit comes either from an external pin or from an internal HDLC transmitter, and one input selects which. The block pulses `dl_req` in the bit time of every insertion, so the source can advance one bit. Insertion is qualified by the general data-link enable and the signaling enable. It is not blocked by the frame-alignment-insertion disable or the frame disable, so the bits still go out when either disable is set.

Top module: `e1_sa_inserter`

## Requirements
- R1: During and straight after reset, `ser_out`, `out_vld` and `dl_req` are 0, and the Sa enable register holds 5'b00001, so only Sa4 is enabled.
- R2: Each input bit taken while `bit_vld` is 1 appears on `ser_out` one clock later with `out_vld` = 1. In a cycle after `bit_vld` = 0, `out_vld` is 0 and `ser_out` is 0.
- R3: A cycle with `bit_vld` = 1 and `frm_pulse` = 1 carries bit index 0 (time slot 0, bit 1) of a frame-alignment frame. The index then counts 0 to 255 on each valid bit. The frame type alternates at every wrap. No bit is modified before the first frame pulse. A later pulse resynchronises the count and frame type.
- R4: In a non-frame-alignment frame, the bit at index k-1 (Sa k, k = 4..8) is replaced by the data-link bit when enable bit k-4 of `cfg_sa_en` is set (bit 0 = Sa4, bit 4 = Sa8).
- R5: No bit of a frame-alignment frame is modified.
- R6: Time slot 0 bits 1 to 3 of non-frame-alignment frames, disabled Sa positions and all other time slots pass through unchanged.
- R7: With `src_hdlc` = 1 the inserted bit is `hdlc_bit`; with `src_hdlc` = 0 it is `pin_bit`, sampled in the same cycle.
- R8: Sa insertion happens only when `dl_gen_en` = 0 or `sig_en` = 1; otherwise every bit passes through.
- R9: `fa_ins_dis` and `frame_dis` have no effect on Sa insertion or on the output.
- R10: `dl_req` is 1 for exactly the bit times in which a bit is inserted, in the same cycle as that input bit.
- R11: `cfg_we` = 1 loads `cfg_sa_en` into the enable register at the clock edge. The new enables apply from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_vld | input | 1 | Stream bit present this cycle |
| ser_in | input | 1 | Incoming stream bit |
| frm_pulse | input | 1 | First bit of a frame-alignment frame |
| pin_bit | input | 1 | Data-link bit from the external pin |
| hdlc_bit | input | 1 | Data-link bit from the internal HDLC transmitter |
| src_hdlc | input | 1 | 1 selects HDLC source, 0 selects pin |
| dl_gen_en | input | 1 | General data-link enable (1 blocks Sa insertion unless sig_en) |
| sig_en | input | 1 | Signaling enable |
| fa_ins_dis | input | 1 | Frame-alignment insertion disable |
| frame_dis | input | 1 | Frame disable |
| cfg_we | input | 1 | Write strobe for the Sa enable register |
| cfg_sa_en | input | 5 | New Sa enables, bit 0 = Sa4 … bit 4 = Sa8 |
| ser_out | output | 1 | Outgoing stream bit |
| out_vld | output | 1 | Outgoing bit present |
| dl_req | output | 1 | Data-link bit consumed this cycle |

## Verification
The bench targets the frame boundary. A design that miscounts the 256-bit wrap or the frame-type toggle would insert into frame-alignment frames, or skip non-alignment ones. Streams with gaps in `bit_vld` catch a counter that advances on idle cycles. A resync pulse in mid-frame catches a design that keeps its old phase. An enable write during traffic exposes an off-by-one in when the new enables take effect. Running with the qualification inputs and the two disables in every combination shows a design that gates insertion with the wrong controls.

// File: rtl/e1_sa_pkg.sv
package e1_sa_pkg;
    // Default geometry of one E1 frame and the national-bit field.
    localparam int DEF_FRAME_BITS = 256;
    localparam int DEF_SA_FIRST   = 3;   // bit index of Sa4 inside time slot 0
    localparam int DEF_SA_COUNT   = 5;   // Sa4 .. Sa8

    // Origin of the data-link bit.
    typedef enum logic {
        SRC_PIN  = 1'b0,
        SRC_HDLC = 1'b1
    } dl_src_e;

    // Registered output pair.
    typedef struct packed {
        logic vld;
        logic bit_v;
    } out_pair_t;
endpackage

// File: rtl/e1_ts0_locator.sv
module e1_ts0_locator #(
    parameter int FRAME_BITS = 256,
    localparam int CNT_W     = $clog2(FRAME_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_vld,
    input  logic             frm_pulse,
    output logic [CNT_W-1:0] cur_pos,
    output logic             cur_nfas,
    output logic             cur_sync
);
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_BITS - 1);

    typedef struct packed {
        logic             synced;
        logic             nfas;
        logic [CNT_W-1:0] cnt;
    } loc_t;

    loc_t loc_d, loc_q;

    always_comb begin
        // Position of the bit present this cycle; a frame pulse overrides.
        cur_pos  = frm_pulse ? '0 : loc_q.cnt;
        cur_nfas = frm_pulse ? 1'b0 : loc_q.nfas;
        cur_sync = frm_pulse | loc_q.synced;

        loc_d = loc_q;
        if (bit_vld) begin
            loc_d.synced = cur_sync;
            if (cur_pos == LAST_POS) begin
                loc_d.cnt  = '0;
                loc_d.nfas = ~cur_nfas;
            end else begin
                loc_d.cnt  = cur_pos + 1'b1;
                loc_d.nfas = cur_nfas;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loc_q <= '0;
        end else begin
            loc_q <= loc_d;
        end
    end
endmodule

// File: rtl/e1_sa_cfg.sv
module e1_sa_cfg #(
    parameter int                  SA_COUNT = 5,
    parameter logic [SA_COUNT-1:0] RST_MASK = SA_COUNT'(1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [SA_COUNT-1:0] cfg_sa_en,
    output logic [SA_COUNT-1:0] sa_en
);
    logic [SA_COUNT-1:0] en_d, en_q;

    always_comb begin
        en_d = cfg_we ? cfg_sa_en : en_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= RST_MASK;
        end else begin
            en_q <= en_d;
        end
    end

    assign sa_en = en_q;
endmodule

// File: rtl/e1_sa_select.sv
module e1_sa_select #(
    parameter int SA_FIRST = 3,
    parameter int SA_COUNT = 5,
    parameter int CNT_W    = 8
) (
    input  logic                bit_vld,
    input  logic [CNT_W-1:0]    cur_pos,
    input  logic                cur_nfas,
    input  logic                cur_sync,
    input  logic                qualify,
    input  logic [SA_COUNT-1:0] sa_en,
    output logic                ins
);
    logic [SA_COUNT-1:0] hit;

    // One comparator per national bit position.
    for (genvar g = 0; g < SA_COUNT; g++) begin : g_sa
        localparam logic [CNT_W-1:0] SLOT = CNT_W'(SA_FIRST + g);
        assign hit[g] = sa_en[g] && (cur_pos == SLOT);
    end

    always_comb begin
        ins = bit_vld && cur_sync && cur_nfas && qualify && (|hit);
    end
endmodule

// File: rtl/e1_sa_inserter.sv
module e1_sa_inserter
    import e1_sa_pkg::*;
#(
    parameter int                  FRAME_BITS  = DEF_FRAME_BITS,
    parameter int                  SA_FIRST    = DEF_SA_FIRST,
    parameter int                  SA_COUNT    = DEF_SA_COUNT,
    parameter logic [SA_COUNT-1:0] SA_RST_MASK = SA_COUNT'(1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_vld,
    input  logic                ser_in,
    input  logic                frm_pulse,
    input  logic                pin_bit,
    input  logic                hdlc_bit,
    input  logic                src_hdlc,
    input  logic                dl_gen_en,
    input  logic                sig_en,
    input  logic                fa_ins_dis,
    input  logic                frame_dis,
    input  logic                cfg_we,
    input  logic [SA_COUNT-1:0] cfg_sa_en,
    output logic                ser_out,
    output logic                out_vld,
    output logic                dl_req
);
    localparam int CNT_W = $clog2(FRAME_BITS);

    logic [CNT_W-1:0]    cur_pos;
    logic                cur_nfas;
    logic                cur_sync;
    logic [SA_COUNT-1:0] sa_en;
    logic                qualify;
    logic                ins;
    logic                dl_bit;
    dl_src_e             src_sel;
    out_pair_t           out_d, out_q;

    // The two disables are accepted but never gate the Sa path.
    logic unused_disables;
    assign unused_disables = fa_ins_dis | frame_dis;

    e1_ts0_locator #(
        .FRAME_BITS (FRAME_BITS)
    ) u_loc (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_vld   (bit_vld),
        .frm_pulse (frm_pulse),
        .cur_pos   (cur_pos),
        .cur_nfas  (cur_nfas),
        .cur_sync  (cur_sync)
    );

    e1_sa_cfg #(
        .SA_COUNT (SA_COUNT),
        .RST_MASK (SA_RST_MASK)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sa_en (cfg_sa_en),
        .sa_en     (sa_en)
    );

    e1_sa_select #(
        .SA_FIRST (SA_FIRST),
        .SA_COUNT (SA_COUNT),
        .CNT_W    (CNT_W)
    ) u_sel (
        .bit_vld  (bit_vld),
        .cur_pos  (cur_pos),
        .cur_nfas (cur_nfas),
        .cur_sync (cur_sync),
        .qualify  (qualify),
        .sa_en    (sa_en),
        .ins      (ins)
    );

    always_comb begin
        qualify = ~dl_gen_en | sig_en;
        src_sel = dl_src_e'(src_hdlc);
        dl_bit  = (src_sel == SRC_HDLC) ? hdlc_bit : pin_bit;

        out_d.vld   = bit_vld;
        out_d.bit_v = bit_vld & (ins ? dl_bit : ser_in);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign ser_out = out_q.bit_v;
    assign out_vld = out_q.vld;
    assign dl_req  = ins;
endmodule

// File: rtl/e1_sa_inserter_chk.sv
module e1_sa_inserter_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_vld,
    input logic ser_in,
    input logic frm_pulse,
    input logic pin_bit,
    input logic hdlc_bit,
    input logic src_hdlc,
    input logic dl_gen_en,
    input logic sig_en,
    input logic ser_out,
    input logic out_vld,
    input logic dl_req
);
    // R10
    req_needs_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dl_req |-> bit_vld);

    // R8
    qual_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dl_gen_en && !sig_en) |-> !dl_req);

    // R5
    fas_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld && frm_pulse) |-> !dl_req);

    // R2
    out_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_vld |=> out_vld);

    // R2
    out_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_vld |=> (!out_vld && !ser_out));

    // R6
    pass_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld && !dl_req) |=> (ser_out == $past(ser_in)));

    // R7
    hdlc_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dl_req && src_hdlc) |=> (ser_out == $past(hdlc_bit)));

    // R4
    pin_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dl_req && !src_hdlc) |=> (ser_out == $past(pin_bit)));
endmodule

bind e1_sa_inserter e1_sa_inserter_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_vld   (bit_vld),
    .ser_in    (ser_in),
    .frm_pulse (frm_pulse),
    .pin_bit   (pin_bit),
    .hdlc_bit  (hdlc_bit),
    .src_hdlc  (src_hdlc),
    .dl_gen_en (dl_gen_en),
    .sig_en    (sig_en),
    .ser_out   (ser_out),
    .out_vld   (out_vld),
    .dl_req    (dl_req)
);

// File: tb/e1_sa_inserter_tb.sv
module e1_sa_inserter_tb;
    localparam int FB = 256;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0;
    logic bit_vld = 1'b0, ser_in = 1'b0, frm_pulse = 1'b0;
    logic pin_bit = 1'b0, hdlc_bit = 1'b0, src_hdlc = 1'b0;
    logic dl_gen_en = 1'b0, sig_en = 1'b0, fa_ins_dis = 1'b0, frame_dis = 1'b0;
    logic cfg_we = 1'b0;
    logic [4:0] cfg_sa_en = 5'b0;
    logic ser_out, out_vld, dl_req;

    e1_sa_inserter u_dut (
        .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .ser_in(ser_in),
        .frm_pulse(frm_pulse), .pin_bit(pin_bit), .hdlc_bit(hdlc_bit),
        .src_hdlc(src_hdlc), .dl_gen_en(dl_gen_en), .sig_en(sig_en),
        .fa_ins_dis(fa_ins_dis), .frame_dis(frame_dis), .cfg_we(cfg_we),
        .cfg_sa_en(cfg_sa_en), .ser_out(ser_out), .out_vld(out_vld),
        .dl_req(dl_req)
    );

    int checks = 0;
    int fails = 0;
    string scen = "reset";

    // Behavioural reference state.
    int pos_m = 0;
    bit nfas_m = 1'b0;
    bit sync_m = 1'b0;
    logic [4:0] sa_m = 5'b00001;

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s [%s] t=%0t: actual=%b expected=%b", tag, scen, $time, act, exp);
        end
    endtask

    // One bit time: drive at negedge, check request, then check output next negedge.
    task automatic step(input logic v, input logic fp, input logic we, input logic [4:0] wv);
        int p;
        bit par, sy, ins, in_sa, en_sa;
        logic exp_out;
        string tq, to;
        bit_vld   = v;
        frm_pulse = fp;
        ser_in    = 1'($urandom);
        pin_bit   = 1'($urandom);
        hdlc_bit  = 1'($urandom);
        cfg_we    = we;
        cfg_sa_en = wv;
        #1;
        p     = fp ? 0 : pos_m;
        par   = fp ? 1'b0 : nfas_m;
        sy    = fp | sync_m;
        in_sa = (p >= 3) && (p <= 7);
        en_sa = in_sa && sa_m[p-3];
        ins   = v && sy && par && en_sa && (!dl_gen_en || sig_en);
        if (ins)                          tq = "R10";
        else if (!sy)                     tq = "R3";
        else if (!par)                    tq = "R5";
        else if (en_sa)                   tq = "R8";
        else                              tq = "R6";
        chk(tq, dl_req, ins);
        exp_out = v ? (ins ? (src_hdlc ? hdlc_bit : pin_bit) : ser_in) : 1'b0;
        to = ins ? (src_hdlc ? "R7" : "R4") : "R2";
        @(posedge clk);
        if (v) begin
            sync_m = sy;
            if (p == FB - 1) begin
                pos_m  = 0;
                nfas_m = !par;
            end else begin
                pos_m  = p + 1;
                nfas_m = par;
            end
        end
        if (we) sa_m = wv;
        @(negedge clk);
        chk(to, ser_out, exp_out);
        chk("R2", out_vld, v);
    endtask

    task automatic run(input int n, input int pct);
        for (int i = 0; i < n; i++) begin
            step((($urandom % 100) < pct) ? 1'b1 : 1'b0, 1'b0, 1'b0, 5'b0);
        end
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R2 watchdog: actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1", ser_out, 1'b0);
        chk("R1", out_vld, 1'b0);
        chk("R1", dl_req, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        scen = "R3 no frame pulse yet";
        run(300, 100);

        scen = "R1 default enables, only Sa4";
        step(1'b1, 1'b1, 1'b0, 5'b0);
        run(2 * FB, 100);

        scen = "R11 write all enables, pin source R4";
        step(1'b1, 1'b0, 1'b1, 5'b11111);
        run(2 * FB, 100);

        scen = "R7 hdlc source";
        src_hdlc = 1'b1;
        run(2 * FB, 100);

        scen = "R8 link enabled, signaling off";
        dl_gen_en = 1'b1;
        run(2 * FB, 100);

        scen = "R8 link enabled, signaling on";
        sig_en = 1'b1;
        run(2 * FB, 100);

        scen = "R9 both disables set";
        dl_gen_en = 1'b0; sig_en = 1'b0; src_hdlc = 1'b0;
        fa_ins_dis = 1'b1; frame_dis = 1'b1;
        run(2 * FB, 100);

        scen = "R2 gapped stream, mask 10100";
        fa_ins_dis = 1'b0; frame_dis = 1'b0;
        step(1'b1, 1'b0, 1'b1, 5'b10100);
        run(3 * FB, 65);

        scen = "R3 mid-frame resync";
        run(100, 100);
        step(1'b1, 1'b1, 1'b0, 5'b0);
        run(2 * FB, 100);

        scen = "R11 enable change mid-frame";
        step(1'b1, 1'b1, 1'b0, 5'b0);
        run(FB + 4, 100);
        step(1'b1, 1'b0, 1'b1, 5'b01010);
        run(FB + 20, 100);
        step(1'b0, 1'b0, 1'b0, 5'b0);

        summary();
        $finish;
    end
endmodule